// File: doc/BRIEF.md
# Escaped Stream Decoder

This block takes a byte stream arriving from a host link and separates it into two kinds of traffic. An escape byte marks in-band control. An escape followed by a command byte sets or clears one of five control levels. Two escapes in a row stand for one literal data byte with the escape value. All other bytes are data, and the data form memory write bursts.

A burst starts with three little-endian 16-bit header words: a target word, a first word address and a last word address. The last address is inclusive. The payload words that follow go out on a memory write port, one word per write, to consecutive addresses. The target word selects a board and one of three DACs on that board. A burst that names a different board than the board strap, or a DAC index of 3 or more, is read through to its end and nothing is written.

Top module: `esc_stream_decoder`

## Requirements
- R1: While reset is high and right after it, `cmd_level` and `cmd_pulse` are all zero and `mem_we` is low. `in_ready` is high whenever reset is low.
- R2: An escape (default 0xA5) followed by a command byte forms a command. In the command byte, bits [7:1] hold the index and bit 0 is a clear flag. Indices 0 to 4 are RESET, TRIGGER, ARM, DCM and START, and each drives `cmd_level` bit 0 to 4 in that order. With bit 0 = 0 the bit is set, and with bit 0 = 1 it is cleared. `cmd_level` changes only in a cycle where `cmd_pulse` is nonzero.
- R3: Each accepted command produces exactly one single-cycle pulse on `cmd_pulse`, in the bit of its index. At most one pulse bit is high at a time.
- R4: Two escape bytes in a row are delivered to the write path as one data byte equal to the escape value.
- R5: An escape followed by a byte that is neither an escape nor an index 0 to 4 changes no level, produces no pulse and no data byte. The decoder then returns to idle.
- R6: The header is target, first address, last address, each a 16-bit word with the low byte first. The payload words, low byte first, are written to addresses first..last inclusive, with the address rising by one per word. After the last word the next word is parsed as a new target.
- R7: Target bits [3:0] hold the DAC index and bits [15:4] hold the board number. `mem_dac` carries the DAC index of the burst.
- R8: A burst whose board number differs from `board_id` writes nothing. The words that follow it are still parsed as a new burst.
- R9: A burst with a DAC index of 3 or more writes nothing.
- R10: A RESET command (set or clear) abandons any burst in progress and any half-received word. The next data byte starts a new target word. No write occurs in the cycle after the RESET pulse.
- R11: Commands other than RESET that arrive between payload words do not disturb the burst.
- R12: Each write is a one-cycle `mem_we` pulse, successive writes are at least two cycles apart, and `mem_dac` is below 3 whenever `mem_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte accepted (high out of reset) |
| board_id | input | BOARD_W | Board address strap |
| cmd_level | output | NUM_CMD | Current control levels, bit i = command index i |
| cmd_pulse | output | NUM_CMD | One-cycle strobe for each accepted command |
| mem_we | output | 1 | Memory write enable |
| mem_dac | output | DAC_W | DAC select of the write |
| mem_addr | output | AW | Word address of the write |
| mem_wdata | output | 16 | Write data |

## Verification
Commit of a finished payload word to the write port falls in the same cycle as the decoder holding an escape that has just arrived for the next byte. The next cycle then decides whether that escape turns into a command, a literal byte or nothing. The bench provokes this in three ways: it places TRIGGER commands and an invalid escape between payload words, it sends a RESET right after a complete word plus a stray low byte, and it puts stuffed escape values inside payload words. Each case is judged by comparing the full list of captured writes (DAC, address, data) and the control levels against values worked out from the requirements.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;

  // Command indices in the order the command byte encodes them
  typedef enum logic [2:0] {
    CMD_RESET   = 3'd0,
    CMD_TRIGGER = 3'd1,
    CMD_ARM     = 3'd2,
    CMD_DCM     = 3'd3,
    CMD_START   = 3'd4
  } cmd_e;

  // Header and payload parsing phases
  typedef enum logic [1:0] {
    PH_TGT   = 2'd0,
    PH_FIRST = 2'd1,
    PH_LAST  = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  localparam int WORD_W = 16;
  localparam int DAC_FIELD_W = 4;

endpackage

// File: rtl/esc_unstuffer.sv
module esc_unstuffer #(
  parameter logic [7:0] ESC_BYTE = 8'hA5,
  parameter int NUM_CMD = 5,
  localparam int IDX_W = $clog2(NUM_CMD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [7:0]       in_byte,
  output logic             dat_vld,
  output logic [7:0]       dat_byte,
  output logic             cmd_vld,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             cmd_dis
);

  localparam logic [6:0] CMD_LIM = 7'(NUM_CMD);

  logic esc_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      esc_pend <= 1'b0;
      dat_vld  <= 1'b0;
      dat_byte <= '0;
      cmd_vld  <= 1'b0;
      cmd_idx  <= '0;
      cmd_dis  <= 1'b0;
    end else begin
      dat_vld <= 1'b0;
      cmd_vld <= 1'b0;
      if (in_vld) begin
        if (!esc_pend) begin
          if (in_byte == ESC_BYTE) begin
            esc_pend <= 1'b1;
          end else begin
            dat_vld  <= 1'b1;
            dat_byte <= in_byte;
          end
        end else begin
          esc_pend <= 1'b0;
          if (in_byte == ESC_BYTE) begin
            // doubled escape collapses into one literal byte
            dat_vld  <= 1'b1;
            dat_byte <= ESC_BYTE;
          end else if (in_byte[7:1] < CMD_LIM) begin
            cmd_vld <= 1'b1;
            cmd_idx <= in_byte[IDX_W:1];
            cmd_dis <= in_byte[0];
          end
          // any other byte after an escape is dropped
        end
      end
    end
  end

endmodule

// File: rtl/cmd_bank.sv
module cmd_bank #(
  parameter int NUM_CMD = 5,
  localparam int IDX_W = $clog2(NUM_CMD)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_vld,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic               cmd_dis,
  output logic [NUM_CMD-1:0] level,
  output logic [NUM_CMD-1:0] pulse
);

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    logic hit;
    assign hit = cmd_vld && (cmd_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        level[g] <= 1'b0;
        pulse[g] <= 1'b0;
      end else begin
        pulse[g] <= hit;
        if (hit) level[g] <= ~cmd_dis;
      end
    end
  end

endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              dat_vld,
  input  logic [7:0]        dat_byte,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);

  logic       have_lo;
  logic [7:0] lo_q;

  // low byte arrives first; the word completes with the high byte
  assign word_vld = dat_vld && have_lo && !clear;
  assign word     = {dat_byte, lo_q};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have_lo <= 1'b0;
      lo_q    <= '0;
    end else if (dat_vld) begin
      have_lo <= ~have_lo;
      if (!have_lo) lo_q <= dat_byte;
    end
  end

endmodule

// File: rtl/write_framer.sv
module write_framer
  import esc_dec_pkg::*;
#(
  parameter int AW = 16,
  parameter int BOARD_W = 4,
  parameter int NUM_DAC = 3,
  parameter int DAC_W = 2,
  localparam int BF_W = WORD_W - DAC_FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic [BOARD_W-1:0] board_id,
  output logic              mem_we,
  output logic [DAC_W-1:0]  mem_dac,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);

  localparam logic [DAC_FIELD_W-1:0] DAC_LIM = DAC_FIELD_W'(NUM_DAC);

  phase_e           phase;
  logic             tgt_ok;
  logic [DAC_W-1:0] dac_q;
  logic [AW-1:0]    cur_q;
  logic [AW-1:0]    last_q;
  logic [BF_W-1:0]  board_ext;
  logic             board_hit;
  logic             dac_hit;

  assign board_ext = {{(BF_W-BOARD_W){1'b0}}, board_id};
  assign board_hit = (word[WORD_W-1:DAC_FIELD_W] == board_ext);
  assign dac_hit   = (word[DAC_FIELD_W-1:0] < DAC_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_TGT;
      tgt_ok    <= 1'b0;
      dac_q     <= '0;
      cur_q     <= '0;
      last_q    <= '0;
      mem_we    <= 1'b0;
      mem_dac   <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (abort) begin
        phase <= PH_TGT;
      end else if (word_vld) begin
        unique case (phase)
          PH_TGT: begin
            tgt_ok <= board_hit && dac_hit;
            dac_q  <= word[DAC_W-1:0];
            phase  <= PH_FIRST;
          end
          PH_FIRST: begin
            cur_q <= word[AW-1:0];
            phase <= PH_LAST;
          end
          PH_LAST: begin
            last_q <= word[AW-1:0];
            phase  <= PH_DATA;
          end
          PH_DATA: begin
            if (tgt_ok) begin
              mem_we    <= 1'b1;
              mem_dac   <= dac_q;
              mem_addr  <= cur_q;
              mem_wdata <= word;
            end
            if (cur_q == last_q) phase <= PH_TGT;
            else cur_q <= cur_q + 1'b1;
          end
          default: phase <= PH_TGT;
        endcase
      end
    end
  end

endmodule

// File: rtl/esc_stream_decoder.sv
module esc_stream_decoder
  import esc_dec_pkg::*;
#(
  parameter logic [7:0] ESC_BYTE = 8'hA5,
  parameter int NUM_CMD = 5,
  parameter int NUM_DAC = 3,
  parameter int DAC_W = 2,
  parameter int BOARD_W = 4,
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  input  logic [BOARD_W-1:0] board_id,
  output logic [NUM_CMD-1:0] cmd_level,
  output logic [NUM_CMD-1:0] cmd_pulse,
  output logic               mem_we,
  output logic [DAC_W-1:0]   mem_dac,
  output logic [AW-1:0]      mem_addr,
  output logic [15:0]        mem_wdata
);

  localparam int IDX_W = $clog2(NUM_CMD);

  logic             dat_vld;
  logic [7:0]       dat_byte;
  logic             cmd_vld;
  logic [IDX_W-1:0] cmd_idx;
  logic             cmd_dis;
  logic             abort;
  logic             word_vld;
  logic [WORD_W-1:0] word;

  // every byte is taken in the cycle it is offered
  assign in_ready = ~rst;
  assign abort    = cmd_vld && (cmd_idx == IDX_W'(CMD_RESET));

  esc_unstuffer #(.ESC_BYTE(ESC_BYTE), .NUM_CMD(NUM_CMD)) unstuff_i (
    .clk(clk), .rst(rst),
    .in_vld(in_valid), .in_byte(in_data),
    .dat_vld(dat_vld), .dat_byte(dat_byte),
    .cmd_vld(cmd_vld), .cmd_idx(cmd_idx), .cmd_dis(cmd_dis)
  );

  cmd_bank #(.NUM_CMD(NUM_CMD)) cmds_i (
    .clk(clk), .rst(rst),
    .cmd_vld(cmd_vld), .cmd_idx(cmd_idx), .cmd_dis(cmd_dis),
    .level(cmd_level), .pulse(cmd_pulse)
  );

  word_assembler #(.WORD_W(WORD_W)) words_i (
    .clk(clk), .rst(rst), .clear(abort),
    .dat_vld(dat_vld), .dat_byte(dat_byte),
    .word_vld(word_vld), .word(word)
  );

  write_framer #(.AW(AW), .BOARD_W(BOARD_W), .NUM_DAC(NUM_DAC), .DAC_W(DAC_W)) framer_i (
    .clk(clk), .rst(rst), .abort(abort),
    .word_vld(word_vld), .word(word), .board_id(board_id),
    .mem_we(mem_we), .mem_dac(mem_dac), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/esc_dec_checker.sv
module esc_dec_checker #(
  parameter int NUM_CMD = 5,
  parameter int NUM_DAC = 3,
  parameter int DAC_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CMD-1:0] cmd_level,
  input logic [NUM_CMD-1:0] cmd_pulse,
  input logic               mem_we,
  input logic [DAC_W-1:0]   mem_dac
);

  // R3: never more than one strobe at once
  p_pulse_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_pulse));

  // R2: levels move only alongside a strobe
  p_level_on_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_level != $past(cmd_level)) |-> (cmd_pulse != '0));

  // R12: write target always names an existing DAC
  p_dac_range_r12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (int'(mem_dac) < NUM_DAC));

  // R12: writes are separated by at least one idle cycle
  p_write_gap_r12: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R10: a RESET strobe is not followed by a write
  p_reset_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_pulse[0] |=> !mem_we);

endmodule

bind esc_stream_decoder esc_dec_checker #(
  .NUM_CMD(NUM_CMD), .NUM_DAC(NUM_DAC), .DAC_W(DAC_W)
) chk_i (
  .clk(clk), .rst(rst), .cmd_level(cmd_level), .cmd_pulse(cmd_pulse),
  .mem_we(mem_we), .mem_dac(mem_dac)
);

// File: tb/esc_stream_decoder_tb_top.sv
module esc_stream_decoder_tb_top;

  localparam logic [7:0] ESC = 8'hA5;
  localparam logic [3:0] BOARD = 4'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic [3:0]  board_id = BOARD;
  logic [4:0]  cmd_level;
  logic [4:0]  cmd_pulse;
  logic        mem_we;
  logic [1:0]  mem_dac;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;

  int checks = 0;
  int fails = 0;
  int pulse_cnt[5];
  int q_dac[$];
  int q_addr[$];
  int q_data[$];

  always #2 clk = ~clk;

  esc_stream_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .board_id(board_id),
    .cmd_level(cmd_level), .cmd_pulse(cmd_pulse),
    .mem_we(mem_we), .mem_dac(mem_dac), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // capture writes and strobes away from the active edge
  always @(negedge clk) begin
    if (!rst && mem_we === 1'b1) begin
      q_dac.push_back(int'(mem_dac));
      q_addr.push_back(int'(mem_addr));
      q_data.push_back(int'(mem_wdata));
    end
    for (int i = 0; i < 5; i++)
      if (!rst && cmd_pulse[i] === 1'b1) pulse_cnt[i]++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic raw_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic data_byte(input logic [7:0] b);
    if (b == ESC) raw_byte(ESC);
    raw_byte(b);
  endtask

  task automatic send_word(input logic [15:0] w);
    data_byte(w[7:0]);
    data_byte(w[15:8]);
  endtask

  task automatic send_cmd(input int idx, input bit dis);
    raw_byte(ESC);
    raw_byte({7'(idx), dis});
  endtask

  task automatic send_hdr(input logic [15:0] tgt, input logic [15:0] first, input logic [15:0] last);
    send_word(tgt);
    send_word(first);
    send_word(last);
  endtask

  task automatic clear_log();
    q_dac.delete();
    q_addr.delete();
    q_data.delete();
  endtask

  task automatic chk_wr(input string req, input int k, input int dac, input int addr, input int data);
    if (k >= q_addr.size()) begin
      chk({req, " write missing"}, q_addr.size(), k + 1);
    end else begin
      chk({req, " dac"}, q_dac[k], dac);
      chk({req, " addr"}, q_addr[k], addr);
      chk({req, " data"}, q_data[k], data);
    end
  endtask

  // R1
  task automatic t_reset();
    chk("R1 ready low in reset", int'(in_ready), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    chk("R1 levels", int'(cmd_level), 0);
    chk("R1 pulses", int'(cmd_pulse), 0);
    chk("R1 no write", int'(mem_we), 0);
    chk("R1 ready", int'(in_ready), 1);
  endtask

  // R2 R3
  task automatic t_commands();
    for (int i = 0; i < 5; i++) begin
      send_cmd(i, 1'b0);
      idle(3);
      chk("R2 set level", int'(cmd_level[i]), 1);
      chk("R3 one pulse", pulse_cnt[i], 1);
    end
    chk("R2 all set", int'(cmd_level), 5'h1f);
    for (int i = 4; i >= 0; i--) begin
      send_cmd(i, 1'b1);
      idle(3);
      chk("R2 clear level", int'(cmd_level[i]), 0);
      chk("R3 second pulse", pulse_cnt[i], 2);
    end
    chk("R2 all clear", int'(cmd_level), 0);
  endtask

  // R6 R7 R12
  task automatic t_dac_writes();
    for (int d = 0; d < 3; d++) begin
      clear_log();
      send_hdr(16'({BOARD, 4'(d)}), 16'(16'h0100 * d + 16'h0010), 16'(16'h0100 * d + 16'h0013));
      for (int k = 0; k < 4; k++) send_word(16'(16'h1000 * d + 16'h0301 + k));
      idle(4);
      chk("R6 write count", q_addr.size(), 4);
      for (int k = 0; k < 4; k++)
        chk_wr("R7 R6 dac burst", k, d, 'h0100 * d + 'h10 + k, 'h1000 * d + 'h0301 + k);
    end
  endtask

  // R4
  task automatic t_stuffing();
    clear_log();
    send_hdr({BOARD, 4'd1}, 16'h0020, 16'h0022);
    send_word(16'hA5A5);
    send_word(16'h12A5);
    send_word(16'hA534);
    idle(4);
    chk("R4 count", q_addr.size(), 3);
    chk_wr("R4 both bytes escaped", 0, 1, 'h20, 'hA5A5);
    chk_wr("R4 low byte escaped", 1, 1, 'h21, 'h12A5);
    chk_wr("R4 high byte escaped", 2, 1, 'h22, 'hA534);
  endtask

  // R8
  task automatic t_other_board();
    clear_log();
    send_hdr({BOARD + 4'd1, 4'd0}, 16'h0040, 16'h0041);
    send_word(16'hDEAD);
    send_word(16'hBEEF);
    send_hdr({BOARD, 4'd2}, 16'h0050, 16'h0050);
    send_word(16'h7777);
    idle(4);
    chk("R8 only matching burst written", q_addr.size(), 1);
    chk_wr("R8 following burst", 0, 2, 'h50, 'h7777);
  endtask

  // R9
  task automatic t_dac3();
    clear_log();
    send_hdr({BOARD, 4'd3}, 16'h0060, 16'h0061);
    send_word(16'h1111);
    send_word(16'h2222);
    send_hdr({BOARD, 4'd15}, 16'h0060, 16'h0060);
    send_word(16'h3333);
    idle(4);
    chk("R9 no write for dac>=3", q_addr.size(), 0);
  endtask

  // R5
  task automatic t_bad_escape();
    int snap[5];
    for (int i = 0; i < 5; i++) snap[i] = pulse_cnt[i];
    clear_log();
    send_hdr({BOARD, 4'd0}, 16'h0070, 16'h0071);
    send_word(16'h4455);
    raw_byte(ESC);
    raw_byte(8'h0A);
    raw_byte(ESC);
    raw_byte(8'hFE);
    send_word(16'h6677);
    idle(4);
    chk("R5 levels untouched", int'(cmd_level), 0);
    for (int i = 0; i < 5; i++) chk("R5 no pulse", pulse_cnt[i], snap[i]);
    chk("R5 no extra data", q_addr.size(), 2);
    chk_wr("R5 word before", 0, 0, 'h70, 'h4455);
    chk_wr("R5 word after", 1, 0, 'h71, 'h6677);
  endtask

  // R10
  task automatic t_reset_abort();
    clear_log();
    send_hdr({BOARD, 4'd1}, 16'h0080, 16'h0083);
    send_word(16'hAAAA);
    data_byte(8'h99);
    send_cmd(0, 1'b0);
    send_hdr({BOARD, 4'd2}, 16'h0090, 16'h0090);
    send_word(16'hC0DE);
    idle(4);
    chk("R10 level set", int'(cmd_level[0]), 1);
    chk("R10 count", q_addr.size(), 2);
    chk_wr("R10 word before abort", 0, 1, 'h80, 'hAAAA);
    chk_wr("R10 new burst after abort", 1, 2, 'h90, 'hC0DE);
    clear_log();
    send_hdr({BOARD, 4'd0}, 16'h00A0, 16'h00A1);
    send_cmd(0, 1'b1);
    send_hdr({BOARD, 4'd0}, 16'h00B0, 16'h00B0);
    send_word(16'h5A5A);
    idle(4);
    chk("R10 clear level", int'(cmd_level[0]), 0);
    chk("R10 abort in header", q_addr.size(), 1);
    chk_wr("R10 header restarted", 0, 0, 'hB0, 'h5A5A);
  endtask

  // R11
  task automatic t_cmd_mid_write();
    clear_log();
    send_hdr({BOARD, 4'd2}, 16'hFFFE, 16'hFFFF);
    send_word(16'h0102);
    send_cmd(1, 1'b0);
    send_cmd(4, 1'b0);
    send_word(16'h0304);
    idle(4);
    chk("R11 levels", int'(cmd_level), 5'b10010);
    chk("R11 count", q_addr.size(), 2);
    chk_wr("R11 first", 0, 2, 'hFFFE, 'h0102);
    chk_wr("R11 second", 1, 2, 'hFFFF, 'h0304);
    send_cmd(1, 1'b1);
    send_cmd(4, 1'b1);
    idle(3);
    chk("R11 cleared", int'(cmd_level), 0);
  endtask

  // R6 single-word bursts back to back
  task automatic t_single();
    clear_log();
    send_hdr({BOARD, 4'd1}, 16'h0200, 16'h0200);
    send_word(16'h1234);
    send_hdr({BOARD, 4'd0}, 16'h0300, 16'h0300);
    send_word(16'h5678);
    idle(4);
    chk("R6 single count", q_addr.size(), 2);
    chk_wr("R6 single a", 0, 1, 'h200, 'h1234);
    chk_wr("R6 single b", 1, 0, 'h300, 'h5678);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) pulse_cnt[i] = 0;
    repeat (4) @(negedge clk);
    t_reset();
    t_commands();
    t_dac_writes();
    t_stuffing();
    t_other_board();
    t_dac3();
    t_bad_escape();
    t_reset_abort();
    t_cmd_mid_write();
    t_single();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule